// File: doc/BRIEF.md
# Raster Frame and Window Sync Generator

This block produces the timing of a digital video port for a raster-scan image source. A column counter and a row counter step through a programmable frame. A programmable window inside the frame marks the active picture. The block drives a horizontal sync, a vertical sync, a vertical-reference flag and a colour-site tag. It also drives an output data bus that carries either the incoming pixel or a programmable blanking constant. The frame may be larger than the window, so extra blanking columns and rows slow the frame rate while the pixel rate stays fixed.

A pixel-enable input sets the pace of the counters. A half-rate mode advances the position only on every second enabled clock and drives a divided pixel clock. A half-width mode shortens the horizontal sync to half of the window width. The frame, window and vertical-sync settings are captured into shadow copies at reset and at each frame wrap, so a change made mid-frame never tears a picture. Polarity, mode and blanking inputs act at once. The pixel input has no valid/ready handshake. The raster is free-running and applies no back-pressure: the source must present the pixel for the current position on every enabled clock.

Top module: `fsg_sync_gen`

## Requirements
- R1: On each step the column counts 0 to framewidth and then returns to 0 while the row advances. The row counts 0 to frameheight and then returns to 0, so a frame is (framewidth+1)×(frameheight+1) steps. This holds when framewidth is the largest value its field holds.
- R2: The position advances only on clocks where pix_en is 1. While pix_en is 0, the sync, reference and colour-tag outputs hold their values.
- R3: The frame size, window corners and vertical-sync rows are taken from the inputs at reset and on the step that leaves the last position of the frame. A change at any other time has no effect until that wrap.
- R4: The horizontal sync is active while the column lies in [win_x1, win_x2]. When hs_vgate is 1 it also requires the row to lie in [win_y1, win_y2]. When hs_vgate is 0 it appears on every row.
- R5: vref_o is 1 (active high) while the row lies in [win_y1, win_y2]. The vertical sync is active for rows with vs_start ≤ row < vs_stop, and it is never active when vs_start equals vs_stop.
- R6: hs_pol and vs_pol each pick their sync's level independently: 0 makes the sync active high, 1 makes it active low.
- R7: data_o carries pix_data when the position lies inside both window ranges. At every other position it carries blank_val.
- R8: With half_rate at 1, the position advances on every second enabled clock. pclk_o equals pclk_pol in the first output clock of each pixel and its inverse in the second. With half_rate at 0, pclk_o holds pclk_pol.
- R9: cfa_o codes the colour site as 0 for red, 1 for green and 2 for blue, counted from the window origin. Rows at an even offset from win_y1 give red at even column offsets and green at odd ones. Rows at an odd offset give green, then blue. cfa_swap at 1 exchanges the two row kinds.
- R10: With half_width at 1, the horizontal sync is active for floor((win_x2−win_x1+1)/2) columns starting at win_x1.
- R11: All outputs are registered. They show the position held one clock earlier, and they all change on the same edge.
- R12: Reset is synchronous and active low. It sets the position to (0,0) and the half-rate phase to 0, holds both syncs at their inactive level, and drives vref_o 0, data_o 0, cfa_o 0 and pclk_o equal to pclk_pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Advance enable for the raster position |
| pix_data | input | DATA_W | Pixel for the current position |
| frame_w | input | COL_W | Last column index of the frame |
| frame_h | input | ROW_W | Last row index of the frame |
| win_x1 | input | COL_W | First window column |
| win_x2 | input | COL_W | Last window column |
| win_y1 | input | ROW_W | First window row |
| win_y2 | input | ROW_W | Last window row |
| vs_start | input | ROW_W | First row of vertical sync |
| vs_stop | input | ROW_W | Row at which vertical sync ends (exclusive) |
| hs_vgate | input | 1 | Restrict horizontal sync to window rows |
| half_width | input | 1 | Halve the horizontal sync length |
| half_rate | input | 1 | Advance on every second enabled clock |
| cfa_swap | input | 1 | Exchange the colour-row order |
| hs_pol | input | 1 | Horizontal sync active low when 1 |
| vs_pol | input | 1 | Vertical sync active low when 1 |
| pclk_pol | input | 1 | Pixel clock output polarity |
| blank_val | input | DATA_W | Data driven outside the window |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| vref_o | output | 1 | Vertical window reference |
| pclk_o | output | 1 | Divided pixel clock |
| cfa_o | output | 2 | Colour-site tag |
| data_o | output | DATA_W | Output data bus |

## Verification
The bench builds the block with COL_W=6, ROW_W=5 and DATA_W=8. With these narrow counters, a frame of a few hundred positions runs through several times per test, and framewidth can be set to the column field's full value of 63, so the wrap at the top of the counter is reached. Small frames also let the shadow capture be tested with a change in mid-frame that takes effect at the very next wrap. The same widths cover each mode: plain, gated and ungated sync, half-width, half-rate with both pixel-clock polarities, colour-row swap and stalls of the enable.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    CFA_RED   = 2'd0,
    CFA_GREEN = 2'd1,
    CFA_BLUE  = 2'd2
  } cfa_e;

  // Typical full-size register settings (858x525 frame, 640x480 window).
  localparam int unsigned DFLT_FRAME_W = 857;
  localparam int unsigned DFLT_FRAME_H = 524;
  localparam int unsigned DFLT_WIN_X1  = 110;
  localparam int unsigned DFLT_WIN_X2  = 749;
  localparam int unsigned DFLT_WIN_Y1  = 12;
  localparam int unsigned DFLT_WIN_Y2  = 491;
endpackage

// File: rtl/fsg_raster_cnt.sv
module fsg_raster_cnt #(
  parameter int COL_W = 11,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             half_rate,
  input  logic [COL_W-1:0] frame_w,
  input  logic [ROW_W-1:0] frame_h,
  input  logic [COL_W-1:0] win_x1,
  input  logic [COL_W-1:0] win_x2,
  input  logic [ROW_W-1:0] win_y1,
  input  logic [ROW_W-1:0] win_y2,
  input  logic [ROW_W-1:0] vs_start,
  input  logic [ROW_W-1:0] vs_stop,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             phase,
  output logic             wrap,
  output logic [COL_W-1:0] sh_fw,
  output logic [ROW_W-1:0] sh_fh,
  output logic [COL_W-1:0] sh_x1,
  output logic [COL_W-1:0] sh_x2,
  output logic [ROW_W-1:0] sh_y1,
  output logic [ROW_W-1:0] sh_y2,
  output logic [ROW_W-1:0] sh_vs0,
  output logic [ROW_W-1:0] sh_vs1
);
  logic step;
  logic col_last;
  logic row_last;

  assign step     = pix_en & (~half_rate | phase);
  assign col_last = (col == sh_fw);
  assign row_last = (row == sh_fh);
  assign wrap     = step & col_last & row_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col    <= '0;
      row    <= '0;
      phase  <= 1'b0;
      sh_fw  <= frame_w;
      sh_fh  <= frame_h;
      sh_x1  <= win_x1;
      sh_x2  <= win_x2;
      sh_y1  <= win_y1;
      sh_y2  <= win_y2;
      sh_vs0 <= vs_start;
      sh_vs1 <= vs_stop;
    end else begin
      if (pix_en && half_rate) phase <= ~phase;
      if (step) begin
        if (col_last) begin
          col <= '0;
          row <= row_last ? '0 : row + ROW_W'(1);
        end else begin
          col <= col + COL_W'(1);
        end
      end
      // Shadow capture only at the frame boundary to avoid tearing.
      if (wrap) begin
        sh_fw  <= frame_w;
        sh_fh  <= frame_h;
        sh_x1  <= win_x1;
        sh_x2  <= win_x2;
        sh_y1  <= win_y1;
        sh_y2  <= win_y2;
        sh_vs0 <= vs_start;
        sh_vs1 <= vs_stop;
      end
    end
  end
endmodule

// File: rtl/fsg_decode.sv
module fsg_decode
  import fsg_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 10
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] x1,
  input  logic [COL_W-1:0] x2,
  input  logic [ROW_W-1:0] y1,
  input  logic [ROW_W-1:0] y2,
  input  logic [ROW_W-1:0] vs0,
  input  logic [ROW_W-1:0] vs1,
  input  logic             half_width,
  input  logic             hs_vgate,
  input  logic             cfa_swap,
  output logic             hs_act,
  output logic             vs_act,
  output logic             vref_act,
  output logic             win_act,
  output logic [1:0]       cfa
);
  logic             x_in;
  logic             y_in;
  logic             hx;
  logic [COL_W:0]   span;
  logic [COL_W:0]   half_span;
  logic [COL_W-1:0] xoff;
  logic [ROW_W-1:0] yoff;
  logic             odd_row;
  cfa_e             site;

  always_comb begin
    x_in      = (col >= x1) && (col <= x2);
    y_in      = (row >= y1) && (row <= y2);
    span      = {1'b0, x2} - {1'b0, x1} + (COL_W+1)'(1);
    half_span = span >> 1;
    xoff      = col - x1;
    yoff      = row - y1;
    hx        = half_width ? ((col >= x1) && ({1'b0, xoff} < half_span)) : x_in;
    hs_act    = hx & (~hs_vgate | y_in);
    vs_act    = (row >= vs0) && (row < vs1);
    vref_act  = y_in;
    win_act   = x_in & y_in;
    odd_row   = yoff[0] ^ cfa_swap;
    if (odd_row) site = xoff[0] ? CFA_BLUE  : CFA_GREEN;
    else         site = xoff[0] ? CFA_GREEN : CFA_RED;
    cfa = site;
  end
endmodule

// File: rtl/fsg_out_stage.sv
module fsg_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_act,
  input  logic              vs_act,
  input  logic              vref_act,
  input  logic              win_act,
  input  logic [1:0]        cfa,
  input  logic              phase,
  input  logic              half_rate,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic              pclk_pol,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [DATA_W-1:0] blank_val,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              vref_o,
  output logic              pclk_o,
  output logic [1:0]        cfa_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_o <= hs_pol;
      vsync_o <= vs_pol;
      vref_o  <= 1'b0;
      pclk_o  <= pclk_pol;
      cfa_o   <= 2'd0;
      data_o  <= '0;
    end else begin
      hsync_o <= hs_act ^ hs_pol;
      vsync_o <= vs_act ^ vs_pol;
      vref_o  <= vref_act;
      pclk_o  <= half_rate ? (phase ^ pclk_pol) : pclk_pol;
      cfa_o   <= cfa;
      data_o  <= win_act ? pix_data : blank_val;
    end
  end
endmodule

// File: rtl/fsg_sync_gen.sv
module fsg_sync_gen #(
  parameter int COL_W  = 11,
  parameter int ROW_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [COL_W-1:0]  frame_w,
  input  logic [ROW_W-1:0]  frame_h,
  input  logic [COL_W-1:0]  win_x1,
  input  logic [COL_W-1:0]  win_x2,
  input  logic [ROW_W-1:0]  win_y1,
  input  logic [ROW_W-1:0]  win_y2,
  input  logic [ROW_W-1:0]  vs_start,
  input  logic [ROW_W-1:0]  vs_stop,
  input  logic              hs_vgate,
  input  logic              half_width,
  input  logic              half_rate,
  input  logic              cfa_swap,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic              pclk_pol,
  input  logic [DATA_W-1:0] blank_val,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              vref_o,
  output logic              pclk_o,
  output logic [1:0]        cfa_o,
  output logic [DATA_W-1:0] data_o
);
  logic [COL_W-1:0] cnt_col;
  logic [ROW_W-1:0] cnt_row;
  logic             cnt_phase;
  logic             cnt_wrap;
  logic [COL_W-1:0] sh_fw, sh_x1, sh_x2;
  logic [ROW_W-1:0] sh_fh, sh_y1, sh_y2, sh_vs0, sh_vs1;
  logic             hs_act, vs_act, vref_act, win_act;
  logic [1:0]       cfa_site;

  fsg_raster_cnt #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .half_rate(half_rate),
    .frame_w(frame_w), .frame_h(frame_h),
    .win_x1(win_x1), .win_x2(win_x2), .win_y1(win_y1), .win_y2(win_y2),
    .vs_start(vs_start), .vs_stop(vs_stop),
    .col(cnt_col), .row(cnt_row), .phase(cnt_phase), .wrap(cnt_wrap),
    .sh_fw(sh_fw), .sh_fh(sh_fh), .sh_x1(sh_x1), .sh_x2(sh_x2),
    .sh_y1(sh_y1), .sh_y2(sh_y2), .sh_vs0(sh_vs0), .sh_vs1(sh_vs1)
  );

  fsg_decode #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dec (
    .col(cnt_col), .row(cnt_row),
    .x1(sh_x1), .x2(sh_x2), .y1(sh_y1), .y2(sh_y2),
    .vs0(sh_vs0), .vs1(sh_vs1),
    .half_width(half_width), .hs_vgate(hs_vgate), .cfa_swap(cfa_swap),
    .hs_act(hs_act), .vs_act(vs_act), .vref_act(vref_act),
    .win_act(win_act), .cfa(cfa_site)
  );

  fsg_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .hs_act(hs_act), .vs_act(vs_act), .vref_act(vref_act), .win_act(win_act),
    .cfa(cfa_site), .phase(cnt_phase), .half_rate(half_rate),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .pclk_pol(pclk_pol),
    .pix_data(pix_data), .blank_val(blank_val),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .vref_o(vref_o),
    .pclk_o(pclk_o), .cfa_o(cfa_o), .data_o(data_o)
  );
endmodule

// File: rtl/fsg_sync_gen_chk.sv
module fsg_sync_gen_chk #(
  parameter int COL_W = 11,
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             half_rate,
  input logic             pclk_pol,
  input logic             pclk_o,
  input logic [COL_W-1:0] col,
  input logic [ROW_W-1:0] row,
  input logic             wrap,
  input logic [COL_W-1:0] sh_fw,
  input logic [ROW_W-1:0] sh_fh,
  input logic [COL_W-1:0] sh_x1,
  input logic [ROW_W-1:0] sh_y1
);
  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (!rst_n) settle <= 2'd0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  a_r1_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col <= sh_fw);
  a_r1_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    row <= sh_fh);
  a_r1_wrap_origin: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (col == '0) && (row == '0));
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(col) && $stable(row));
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(sh_fw) && $stable(sh_fh) && $stable(sh_x1) && $stable(sh_y1));
  a_r8_pclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ((settle >= 2'd2) && $past(half_rate) && $past(half_rate, 2) &&
     $past(pix_en, 2) && ($past(pclk_pol) == $past(pclk_pol, 2)))
    |-> (pclk_o != $past(pclk_o)));
endmodule

bind fsg_sync_gen fsg_sync_gen_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .half_rate(half_rate),
  .pclk_pol(pclk_pol), .pclk_o(pclk_o),
  .col(cnt_col), .row(cnt_row), .wrap(cnt_wrap),
  .sh_fw(sh_fw), .sh_fh(sh_fh), .sh_x1(sh_x1), .sh_y1(sh_y1)
);

// File: tb/sim_fsg_sync_gen.sv
module sim_fsg_sync_gen;
  localparam int CW = 6;
  localparam int RW = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic [CW-1:0] frame_w, win_x1, win_x2;
  logic [RW-1:0] frame_h, win_y1, win_y2, vs_start, vs_stop;
  logic          hs_vgate = 0, half_width = 0, half_rate = 0, cfa_swap = 0;
  logic          hs_pol = 0, vs_pol = 0, pclk_pol = 0;
  logic [DW-1:0] blank_val = 8'h3C;
  logic          hsync_o, vsync_o, vref_o, pclk_o;
  logic [1:0]    cfa_o;
  logic [DW-1:0] data_o;

  fsg_sync_gen #(.COL_W(CW), .ROW_W(RW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_data(pix_data),
    .frame_w(frame_w), .frame_h(frame_h), .win_x1(win_x1), .win_x2(win_x2),
    .win_y1(win_y1), .win_y2(win_y2), .vs_start(vs_start), .vs_stop(vs_stop),
    .hs_vgate(hs_vgate), .half_width(half_width), .half_rate(half_rate),
    .cfa_swap(cfa_swap), .hs_pol(hs_pol), .vs_pol(vs_pol), .pclk_pol(pclk_pol),
    .blank_val(blank_val), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .vref_o(vref_o), .pclk_o(pclk_o), .cfa_o(cfa_o), .data_o(data_o)
  );

  always #5 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  // Independent position model built from the requirements.
  int m_col, m_row, m_ph;
  int s_fw, s_fh, s_x1, s_x2, s_y1, s_y2, s_v0, s_v1;

  typedef struct packed {
    int fw; int fh; int x1; int x2; int y1; int y2; int v0; int v1;
    int hr; int hw; int gt;
    int e_hs; int e_vs; int e_vr; int e_win;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{15, 9, 3, 12, 2, 7, 0, 2, 0, 0, 1,  60,  32,  96,  60},
    '{15, 9, 3, 12, 2, 7, 0, 2, 0, 0, 0, 100,  32,  96,  60},
    '{15, 9, 3,  9, 2, 7, 0, 2, 0, 1, 1,  18,  32,  96,  42},
    '{15, 9, 3, 12, 2, 7, 0, 2, 1, 0, 1, 120,  64, 192, 120},
    '{63, 3,60, 63, 0, 3, 1, 4, 0, 0, 1,  16, 192, 256,  16},
    '{ 7, 7, 0,  7, 0, 7, 3, 3, 0, 0, 1,  64,   0,  64,  64}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(int fw, int fh, int x1, int x2, int y1, int y2, int v0, int v1);
    frame_w = CW'(fw); frame_h = RW'(fh);
    win_x1 = CW'(x1); win_x2 = CW'(x2);
    win_y1 = RW'(y1); win_y2 = RW'(y2);
    vs_start = RW'(v0); vs_stop = RW'(v1);
  endtask

  task automatic load_shadow();
    s_fw = int'(frame_w); s_fh = int'(frame_h);
    s_x1 = int'(win_x1); s_x2 = int'(win_x2);
    s_y1 = int'(win_y1); s_y2 = int'(win_y2);
    s_v0 = int'(vs_start); s_v1 = int'(vs_stop);
  endtask

  // Holds reset, checks the reset outputs (R12), then releases at a negedge.
  task automatic do_reset();
    rst_n = 1'b0;
    pix_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs",
          int'({hsync_o, vsync_o, vref_o, pclk_o, cfa_o, data_o}),
          int'({hs_pol, vs_pol, 1'b0, pclk_pol, 2'b00, 8'h00}));
    rst_n = 1'b1;
    m_col = 0; m_row = 0; m_ph = 0;
    load_shadow();
  endtask

  function automatic int expect_vec(int pix);
    bit xin, yin, hx, hs, vs, win, dc, dr, pc;
    int cfa, dat;
    xin = (m_col >= s_x1) && (m_col <= s_x2);
    yin = (m_row >= s_y1) && (m_row <= s_y2);
    hx  = half_width ? ((m_col >= s_x1) && ((m_col - s_x1) < (s_x2 - s_x1 + 1) / 2)) : xin;
    hs  = hx && (!hs_vgate || yin);
    vs  = (m_row >= s_v0) && (m_row < s_v1);
    win = xin && yin;
    dc  = ((m_col - s_x1) & 1) != 0;
    dr  = (((m_row - s_y1) & 1) != 0) ^ cfa_swap;
    cfa = dr ? (dc ? 2 : 1) : (dc ? 1 : 0);
    dat = win ? pix : int'(blank_val);
    pc  = half_rate ? (m_ph[0] ^ pclk_pol) : pclk_pol;
    return int'({hs ^ hs_pol, vs ^ vs_pol, yin, pc, cfa[1:0], dat[7:0]});
  endfunction

  task automatic model_step(bit en);
    bit step, at_end;
    step   = en && (!half_rate || m_ph != 0);
    at_end = (m_col == s_fw) && (m_row == s_fh);
    if (en && half_rate) m_ph = m_ph ^ 1;
    if (step) begin
      if (m_col == s_fw) begin
        m_col = 0;
        m_row = (m_row == s_fh) ? 0 : m_row + 1;
      end else m_col = m_col + 1;
      if (at_end) load_shadow();
    end
  endtask

  // Cycle-by-cycle comparison. stall: drop pix_en on a pattern.
  // chg_at: cycle at which the second configuration is applied to the inputs.
  int nb_fw, nb_fh, nb_x1, nb_x2, nb_y1, nb_y2, nb_v0, nb_v1;
  task automatic run_cmp(string req, int n, bit stall, int chg_at);
    for (int i = 0; i < n; i++) begin
      int exp, pix;
      bit en;
      if (i == chg_at) set_cfg(nb_fw, nb_fh, nb_x1, nb_x2, nb_y1, nb_y2, nb_v0, nb_v1);
      en = stall ? ((i % 7) >= 3) : 1'b1;
      pix = (i * 37 + 11) & 8'hFF;
      pix_en = en;
      pix_data = DW'(pix);
      exp = expect_vec(pix);
      model_step(en);
      @(negedge clk);
      check(req, int'({hsync_o, vsync_o, vref_o, pclk_o, cfa_o, data_o}), exp);
    end
  endtask

  task automatic count_run(int p, output int c_hs, output int c_vs, output int c_vr, output int c_win);
    c_hs = 0; c_vs = 0; c_vr = 0; c_win = 0;
    pix_en = 1'b1;
    pix_data = 8'hA5;
    repeat (3) @(negedge clk);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      c_hs  += int'(hsync_o);
      c_vs  += int'(vsync_o);
      c_vr  += int'(vref_o);
      c_win += int'(data_o == 8'hA5);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    set_cfg(15, 9, 3, 12, 2, 7, 1, 3);

    // Reset with every polarity inverted (R12).
    hs_pol = 1; vs_pol = 1; pclk_pol = 1;
    do_reset();

    // Table of counts over one full frame period (R1 R4 R5 R7 R8 R10).
    hs_pol = 0; vs_pol = 0; pclk_pol = 0; cfa_swap = 0;
    for (int k = 0; k < 6; k++) begin
      int p, c_hs, c_vs, c_vr, c_win;
      vec_t t;
      t = TBL[k];
      set_cfg(t.fw, t.fh, t.x1, t.x2, t.y1, t.y2, t.v0, t.v1);
      half_rate = t.hr[0]; half_width = t.hw[0]; hs_vgate = t.gt[0];
      do_reset();
      p = (t.fw + 1) * (t.fh + 1) * (t.hr + 1);
      count_run(p, c_hs, c_vs, c_vr, c_win);
      check("R4 R10 hsync count", c_hs, t.e_hs);
      check("R5 vsync count", c_vs, t.e_vs);
      check("R5 vref count", c_vr, t.e_vr);
      check("R7 R1 window data count", c_win, t.e_win);
    end

    // Exact cycles, full rate, active-low hsync, gated (R1 R4 R5 R6 R7 R11).
    half_rate = 0; half_width = 0; hs_vgate = 1;
    hs_pol = 1; vs_pol = 0;
    set_cfg(15, 9, 3, 12, 2, 7, 1, 3);
    do_reset();
    run_cmp("R1 R4 R5 R6 R7 R11 gated", 320, 0, -1);

    // Ungated hsync, active-low vsync (R4 R6).
    hs_vgate = 0; hs_pol = 0; vs_pol = 1;
    do_reset();
    run_cmp("R4 R6 ungated", 160, 0, -1);

    // Half-width sync on an odd window width (R10).
    hs_vgate = 1; vs_pol = 0; half_width = 1;
    set_cfg(15, 9, 3, 9, 2, 7, 1, 3);
    do_reset();
    run_cmp("R10 half width", 160, 0, -1);

    // Half-rate with colour tags, then swapped order and inverted clock (R8 R9).
    half_width = 0; half_rate = 1; pclk_pol = 0; cfa_swap = 0;
    set_cfg(15, 9, 3, 12, 2, 7, 1, 3);
    do_reset();
    run_cmp("R8 R9 half rate", 320, 0, -1);
    cfa_swap = 1; pclk_pol = 1;
    run_cmp("R8 R9 swapped order", 320, 0, -1);

    // Stalled enable in both rates (R2).
    half_rate = 0; cfa_swap = 0; pclk_pol = 0;
    do_reset();
    run_cmp("R2 stall full rate", 210, 1, -1);
    half_rate = 1;
    run_cmp("R2 stall half rate", 210, 1, -1);

    // Mid-frame change must wait for the wrap (R3).
    half_rate = 0;
    set_cfg(15, 9, 3, 12, 2, 7, 1, 3);
    do_reset();
    nb_fw = 11; nb_fh = 6; nb_x1 = 1; nb_x2 = 5; nb_y1 = 1; nb_y2 = 4; nb_v0 = 0; nb_v1 = 1;
    run_cmp("R3 shadow capture", 400, 0, 40);

    // Column field at its largest value (R1).
    set_cfg(63, 2, 60, 63, 0, 2, 1, 2);
    do_reset();
    run_cmp("R1 max column wrap", 400, 0, -1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule